// File: doc/BRIEF.md
# Per-Destination Transmit Time-Slice Gate

This block decides, cycle by cycle, whether the frame waiting at the head of the transmit path may go out now. It holds a small set of time slices (two by default). Each slice has a 32-bit destination tag, a cycle length, and a window given by an opening and a closing microsecond. A free-running microsecond counter per slice walks through the cycle. The slice is "in window" while that counter lies between the opening and closing values, with both ends included.

The transmit side presents the low 32 bits of the pending frame's destination MAC address. A MAC address such as 6c:fd:b9:4c:b1:c1 is tagged as 0xb94cb1c1. If the address equals the tag of at least one slice, the frame may only be sent while one of those matching slices is in window. If no slice claims the address, the frame is never held back.

Configuration comes through simple write strobes that name a slice and a field. Any write to a slice restarts that slice's counter from zero, so a new setting always starts from a known phase.

Top module: `tx_slice_gate`

## Requirements
- R1: After reset every slice has tag 0, cycle value 0, opening value 1 and closing value 0, and its counter is 0. Every `in_window` bit is therefore 0, `tx_permit` is 0 for `dest_tag` = 0 (the tag matches), and `tx_permit` is 1 for any other `dest_tag`.
- R2: A slice counter increases by one on each clock edge at which `us_tick` is 1. It holds its value on edges without a tick.
- R3: On a tick where a slice counter equals that slice's cycle value, the counter returns to 0. The cycle value is the period minus one, so the period is cycle value + 1 ticks.
- R4: `in_window[i]` is 1 exactly when opening ≤ counter ≤ closing for slice i. Both bounds are inclusive.
- R5: When a slice's opening value exceeds its closing value, its `in_window` bit stays 0 for the whole cycle.
- R6: A write is taken on a clock edge with `cfg_we` = 1. `cfg_slice` selects the slice. `cfg_field` selects the field: 0 = destination tag, 1 = cycle value, 2 = opening microsecond, 3 = closing microsecond. The value comes from `cfg_wdata`.
- R7: When `dest_tag` equals no slice tag, `tx_permit` is 1 whatever the window state.
- R8: When `dest_tag` equals one or more slice tags, `tx_permit` is 1 exactly when at least one of those matching slices is in window.
- R9: A write to any field of a slice resets that slice's counter to 0 on the same edge, and this takes priority over a tick on that edge.
- R10: A write to one slice leaves the other slice's counter and fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slice | input | 1 | Slice selected by the write |
| cfg_field | input | 2 | Field selected by the write (0 tag, 1 cycle, 2 opening, 3 closing) |
| cfg_wdata | input | 32 | Write value |
| dest_tag | input | 32 | Low 32 bits of the pending frame's destination address |
| in_window | output | 2 | Per-slice in-window flag |
| tx_permit | output | 1 | Pending frame may be sent now |

## Verification
A write or a tick changes the slice registers on the rising edge where it is sampled. `in_window` is decoded directly from those registers, so it is valid immediately after that same edge. `tx_permit` also follows `dest_tag` combinationally within the same cycle. The bench drives every strobe for exactly one cycle from a falling edge and steps its own counter model at the same point. It samples both outputs shortly after the following falling edge, one register stage after the stimulus. After changing `dest_tag` it waits one time unit before comparing.

// File: rtl/txsg_pkg.sv
// Package: shared field codes for the transmit time-slice gate.
// Assumes: configuration writes carry a 2-bit field selector.
package txsg_pkg;
    typedef enum logic [1:0] {
        FLD_TAG   = 2'd0,
        FLD_CYCLE = 2'd1,
        FLD_OPEN  = 2'd2,
        FLD_CLOSE = 2'd3
    } fld_e;
endpackage

// File: rtl/txsg_slice_cfg.sv
// Module: txsg_slice_cfg
// Holds the four configuration fields of one slice. The field written is chosen
// by wr_field, and wr_en has already been qualified with the slice select.
// Assumes: TAG_W and CNT_W are not larger than DATA_W.
module txsg_slice_cfg #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_field,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TAG_W-1:0]  tag,
    output logic [CNT_W-1:0]  cyc,
    output logic [CNT_W-1:0]  open_us,
    output logic [CNT_W-1:0]  close_us
);
    import txsg_pkg::*;

    fld_e fsel;
    assign fsel = fld_e'(wr_field);

    // Field registers: load the selected field on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag      <= '0;
            cyc      <= '0;
            open_us  <= CNT_W'(1);
            close_us <= '0;
        end else if (wr_en) begin
            case (fsel)
                FLD_TAG:   tag      <= wr_data[TAG_W-1:0];
                FLD_CYCLE: cyc      <= wr_data[CNT_W-1:0];
                FLD_OPEN:  open_us  <= wr_data[CNT_W-1:0];
                FLD_CLOSE: close_us <= wr_data[CNT_W-1:0];
                default:   ;
            endcase
        end
    end

    // R10: fields hold when this slice is not written.
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(tag) && $stable(cyc) && $stable(open_us) && $stable(close_us)));
endmodule

// File: rtl/txsg_slice_timer.sv
// Module: txsg_slice_timer
// Microsecond cycle counter of one slice, plus the inclusive window compare.
// The counter wraps to zero on the tick after it equals the cycle value.
// Assumes: clr is asserted on every configuration write to this slice.
module txsg_slice_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] cyc,
    input  logic [CNT_W-1:0] open_us,
    input  logic [CNT_W-1:0] close_us,
    output logic             in_win
);
    logic [CNT_W-1:0] cnt;

    // Counter: a write clears it, otherwise a tick advances or wraps it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt >= cyc) ? '0 : cnt + CNT_W'(1);
    end

    // Window decode: inclusive on both bounds.
    always_comb begin
        in_win = (cnt >= open_us) && (cnt <= close_us);
    end

    assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= cyc);
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt == cyc) |=> cnt == '0);
    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt < cyc) |=> cnt == $past(cnt) + CNT_W'(1));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
    assert_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (open_us > close_us) |-> !in_win);
endmodule

// File: rtl/tx_slice_gate.sv
// Module: tx_slice_gate
// Top of the per-destination transmit time-slice gate. It builds one config and
// timer pair per slice and combines the tag matches with the window flags into
// the transmit permit.
// Assumes: us_tick is one clock wide; dest_tag is stable while being evaluated.
module tx_slice_gate #(
    parameter int NUM_SLICES = 2,
    parameter int DATA_W     = 32,
    parameter int TAG_W      = 32,
    parameter int CNT_W      = 32,
    localparam int SLICE_W   = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  us_tick,
    input  logic                  cfg_we,
    input  logic [SLICE_W-1:0]    cfg_slice,
    input  logic [1:0]            cfg_field,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic [TAG_W-1:0]      dest_tag,
    output logic [NUM_SLICES-1:0] in_window,
    output logic                  tx_permit
);
    logic [NUM_SLICES-1:0] hit;
    logic [NUM_SLICES-1:0] wr_sel;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] open_us;
        logic [CNT_W-1:0] close_us;

        assign wr_sel[i] = cfg_we && (cfg_slice == SLICE_W'(i));

        txsg_slice_cfg #(.DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_cfg (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[i]), .wr_field(cfg_field),
            .wr_data(cfg_wdata), .tag(tag), .cyc(cyc), .open_us(open_us),
            .close_us(close_us)
        );

        txsg_slice_timer #(.CNT_W(CNT_W)) u_timer (
            .clk(clk), .rst_n(rst_n), .tick(us_tick), .clr(wr_sel[i]),
            .cyc(cyc), .open_us(open_us), .close_us(close_us),
            .in_win(in_window[i])
        );

        assign hit[i] = (tag == dest_tag);
    end

    // Permit: unclaimed destinations pass; claimed ones need an open matching slice.
    always_comb begin
        tx_permit = (hit == '0) || ((hit & in_window) != '0);
    end

    assert_unclaimed_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> tx_permit);
    assert_open_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & in_window) != '0) |-> tx_permit);
    assert_closed_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit != '0) && ((hit & in_window) == '0)) |-> !tx_permit);
    assert_one_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
endmodule

// File: tb/tx_slice_gate_tb.sv
module tx_slice_gate_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_slice = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] dest_tag = '0;
    logic [1:0]  in_window;
    logic        tx_permit;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    int unsigned m_cnt[2], m_cyc[2], m_open[2], m_close[2];
    logic [31:0] m_tag[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_slice_gate u_dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cfg_we(cfg_we),
        .cfg_slice(cfg_slice), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .dest_tag(dest_tag), .in_window(in_window), .tx_permit(tx_permit)
    );

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            m_cnt[s] = 0; m_cyc[s] = 0; m_open[s] = 1; m_close[s] = 0; m_tag[s] = '0;
        end
    endtask

    task automatic compare(string req);
        logic [1:0] ew;
        logic [1:0] mh;
        logic ep;
        #1;
        for (int s = 0; s < 2; s++) begin
            ew[s] = (m_cnt[s] >= m_open[s]) && (m_cnt[s] <= m_close[s]);
            mh[s] = (m_tag[s] == dest_tag);
        end
        ep = (mh == 2'b00) || ((mh & ew) != 2'b00);
        n_vec++;
        if (in_window !== ew || tx_permit !== ep) begin
            n_bad++;
            $display("FAIL %s: in_window=%b tx_permit=%b expected in_window=%b tx_permit=%b",
                     req, in_window, tx_permit, ew, ep);
        end
    endtask

    task automatic cfg(int s, int f, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slice = s[0:0]; cfg_field = f[1:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (f)
            0: m_tag[s] = d;
            1: m_cyc[s] = d;
            2: m_open[s] = d;
            default: m_close[s] = d;
        endcase
        m_cnt[s] = 0;
    endtask

    task automatic tick_check(int n, string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
            for (int s = 0; s < 2; s++)
                m_cnt[s] = (m_cnt[s] >= m_cyc[s]) ? 0 : m_cnt[s] + 1;
            compare(req);
        end
    endtask

    // R1: reset values, seen through the window flags and the permit.
    task automatic t_reset();
        dest_tag = 32'h0;
        compare("R1 tag0 claimed, no window");
        dest_tag = 32'h5;
        compare("R1 unclaimed passes");
    endtask

    // R2/R3/R6: slice 0 with period 5, single-microsecond window at 2.
    task automatic t_wrap();
        cfg(0, 1, 32'd4);
        cfg(0, 2, 32'd2);
        cfg(0, 3, 32'd2);
        dest_tag = 32'h0;
        tick_check(12, "R3 wrap R2 advance");
        repeat (5) @(negedge clk);
        compare("R2 hold without tick");
    endtask

    // R4/R6: slice 1 window 1..3 inclusive in a period of 6.
    task automatic t_inclusive();
        cfg(1, 0, 32'hb94cb1c1);
        cfg(1, 1, 32'd5);
        cfg(1, 2, 32'd1);
        cfg(1, 3, 32'd3);
        dest_tag = 32'hb94cb1c1;
        tick_check(14, "R4 inclusive bounds R6 fields");
    endtask

    // R5: opening after closing gives an empty window.
    task automatic t_empty();
        cfg(0, 0, 32'h11112222);
        cfg(0, 1, 32'd6);
        cfg(0, 2, 32'd4);
        cfg(0, 3, 32'd1);
        dest_tag = 32'h11112222;
        tick_check(10, "R5 empty window blocks");
    endtask

    // R7/R8: unclaimed, claimed by one, claimed by both slices.
    task automatic t_permit();
        cfg(0, 0, 32'hAAAA0001);
        cfg(0, 1, 32'd3);
        cfg(0, 2, 32'd0);
        cfg(0, 3, 32'd1);
        cfg(1, 0, 32'hBBBB0002);
        cfg(1, 1, 32'd3);
        cfg(1, 2, 32'd2);
        cfg(1, 3, 32'd3);
        dest_tag = 32'hCCCC0003;
        tick_check(6, "R7 unclaimed always passes");
        dest_tag = 32'hAAAA0001;
        tick_check(6, "R8 slice0 claim");
        dest_tag = 32'hBBBB0002;
        tick_check(6, "R8 slice1 claim");
        cfg(1, 0, 32'hAAAA0001);
        dest_tag = 32'hAAAA0001;
        tick_check(8, "R8 both claim");
    endtask

    // R9/R10: a write clears only the written slice's counter.
    task automatic t_clear();
        cfg(0, 1, 32'd7);
        cfg(0, 2, 32'd0);
        cfg(0, 3, 32'd0);
        cfg(1, 1, 32'd7);
        cfg(1, 2, 32'd0);
        cfg(1, 3, 32'd0);
        dest_tag = 32'h0;
        tick_check(3, "R9 setup");
        cfg(0, 0, 32'h12345678);
        compare("R9 clear slice0 R10 slice1 untouched");
        tick_check(2, "R10 independent phase");
        // write and tick on the same edge: clear wins
        @(negedge clk);
        us_tick = 1'b1; cfg_we = 1'b1; cfg_slice = 1'b1; cfg_field = 2'd0; cfg_wdata = 32'h0;
        @(negedge clk);
        us_tick = 1'b0; cfg_we = 1'b0;
        m_tag[1] = 32'h0; m_cnt[1] = 0;
        m_cnt[0] = (m_cnt[0] >= m_cyc[0]) ? 0 : m_cnt[0] + 1;
        compare("R9 clear beats tick");
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wrap();
        t_inclusive();
        t_empty();
        t_permit();
        t_clear();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule